// File: doc/BRIEF.md
# Thermal Trip Comparator

This block watches a set of temperature measurement channels, each of which delivers a 12-bit code together with a one-cycle data-ready strobe. The codes run backwards: a smaller code means a hotter die. On every strobe the block compares the new code against three programmable limits per channel. These are an alarm limit, a re-arm (hysteresis) limit that sits on the cooler side of the alarm limit, and a shutdown limit. The results are recorded as sticky flags in a status word.

Software programs the limits and the interrupt enables through a simple write port. It reads the status word from a dedicated output and acknowledges flags by writing ones to the status address. The interrupt line combines every flag whose enable bit is set. A separate shutdown request output stays high for as long as any shutdown flag is pending. The alarm raises once per hot excursion: after it fires, that channel must first report a reading cooler than its re-arm limit before it can raise the alarm again. The shutdown comparison has no such memory.

Top module: `thermal_trip_cmp`

## Requirements
- R1: After reset the status word is zero, the interrupt and shutdown request are low, all limits are zero, all enables are clear, and every channel's alarm is armed.
- R2: A strobe on channel i sets the data-ready flag at status bit 8+i, visible in the cycle after the strobe.
- R3: The alarm limit of channel i sits in bits 27:16 of the register at byte address 0x10+4i. A strobe whose code is strictly below that limit, on an armed channel, sets status bit i and disarms the channel. A code equal to the limit does not set the flag.
- R4: The re-arm limit sits in bits 11:0 of the same register. A disarmed channel re-arms only on a strobe whose code is strictly above that limit. The re-arming strobe itself never sets the alarm flag, and while the channel is disarmed no code sets the flag.
- R5: The shutdown limit of channel i sits in bits 27:16 of the register at 0x20+4i. Every strobe whose code is strictly below it sets status bit 4+i, with no hysteresis.
- R6: Writing to the status address 0x04 clears each flag whose data bit is 1 and leaves the others unchanged. Writing back a value just read clears exactly those flags.
- R7: When a flag is set and cleared in the same cycle, it ends up set.
- R8: The interrupt-enable register at 0x00 uses the same bit positions as the status word. The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R9: The shutdown request is high exactly while at least one shutdown flag is set.
- R10: Flags change to 1 only in the cycle after a strobe. A code below a limit without a strobe, or a limit write, sets nothing.
- R11: Channels are independent: a strobe on one channel sets only that channel's bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | 32 | Write data |
| data_valid | input | NUM_CH (3) | Per-channel data-ready strobe |
| data_code | input | NUM_CH*DATA_W (36) | Per-channel codes, channel i at bits DATA_W*i upward |
| status | output | 32 | Sticky flag word: alarm 0+i, shutdown 4+i, ready 8+i |
| irq | output | 1 | Combined enabled interrupt |
| shut_req | output | 1 | Shutdown request level |

## Verification
The hardest state to reach is a disarmed channel. Reaching it takes a hot reading, then an acknowledge, then readings that sit between the two limits or exactly on the re-arm limit, all of which must leave the alarm silent. The stimulus walks one channel through that path with codes chosen exactly at the limit, one past it and one inside the band. It then confirms that only a strictly cooler reading re-arms the channel and that the next hot reading fires again. The set-versus-clear collision is produced by one cycle that carries both a strobe and a status write targeting the same ready bit.

// File: rtl/thermal_cmp_pkg.sv
package thermal_cmp_pkg;
    // Width of the register data path
    localparam int REG_W     = 32;
    // Field positions inside a limit register
    localparam int HOT_LSB   = 16;
    localparam int REARM_LSB = 0;
    // First bit of each flag group in the status and enable words
    localparam int ALARM_GRP = 0;
    localparam int SHUT_GRP  = 4;
    localparam int READY_GRP = 8;
    // Room per group; channel count must not exceed it
    localparam int GRP_SPAN  = 4;
    // Byte offsets of the register map
    localparam int OFS_ENABLE = 'h00;
    localparam int OFS_STATUS = 'h04;
    localparam int OFS_ALARM  = 'h10;
    localparam int OFS_SHUT   = 'h20;
    localparam int REG_STRIDE = 4;
endpackage

// File: rtl/thermal_chan_cmp.sv
module thermal_chan_cmp
    import thermal_cmp_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 8,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_hot,
    input  logic [DATA_W-1:0] wr_low,
    input  logic              strobe,
    input  logic [DATA_W-1:0] code,
    output logic              set_alarm,
    output logic              set_shut
);
    localparam logic [ADDR_W-1:0] ALARM_ADR = ADDR_W'(OFS_ALARM + REG_STRIDE * CH_IDX);
    localparam logic [ADDR_W-1:0] SHUT_ADR  = ADDR_W'(OFS_SHUT + REG_STRIDE * CH_IDX);

    typedef struct packed {
        logic [DATA_W-1:0] alarm_lim;
        logic [DATA_W-1:0] rearm_lim;
        logic [DATA_W-1:0] shut_lim;
        logic              armed;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     trip_alarm;
    logic     trip_shut;

    always_comb begin
        st_d       = st_q;
        // Hotter means numerically smaller
        trip_alarm = strobe && st_q.armed && (code < st_q.alarm_lim);
        trip_shut  = strobe && (code < st_q.shut_lim);

        if (wr_en && (wr_addr == ALARM_ADR)) begin
            st_d.alarm_lim = wr_hot;
            st_d.rearm_lim = wr_low;
        end
        if (wr_en && (wr_addr == SHUT_ADR)) begin
            st_d.shut_lim = wr_hot;
        end

        if (trip_alarm) begin
            st_d.armed = 1'b0;
        end else if (strobe && !st_q.armed && (code > st_q.rearm_lim)) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{alarm_lim: '0, rearm_lim: '0, shut_lim: '0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign set_alarm = trip_alarm;
    assign set_shut  = trip_shut;
endmodule

// File: rtl/thermal_trip_cmp.sv
module thermal_trip_cmp
    import thermal_cmp_pkg::*;
#(
    parameter int NUM_CH = 3,   // at most GRP_SPAN
    parameter int DATA_W = 12,  // at most 12 to fit the limit fields
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [NUM_CH-1:0]        data_valid,
    input  logic [NUM_CH*DATA_W-1:0] data_code,
    output logic [REG_W-1:0]         status,
    output logic                     irq,
    output logic                     shut_req
);
    localparam logic [ADDR_W-1:0] EN_ADR   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(OFS_STATUS);

    typedef struct packed {
        logic [NUM_CH-1:0] alarm;
        logic [NUM_CH-1:0] shut;
        logic [NUM_CH-1:0] ready;
        logic [NUM_CH-1:0] en_alarm;
        logic [NUM_CH-1:0] en_shut;
        logic [NUM_CH-1:0] en_ready;
    } flag_st_t;

    flag_st_t          fl_d, fl_q;
    logic [NUM_CH-1:0] hit_alarm;
    logic [NUM_CH-1:0] hit_shut;
    logic [NUM_CH-1:0] clr_alarm, clr_shut, clr_ready;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        thermal_chan_cmp #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .CH_IDX (g)
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_hot    (wr_data[HOT_LSB +: DATA_W]),
            .wr_low    (wr_data[REARM_LSB +: DATA_W]),
            .strobe    (data_valid[g]),
            .code      (data_code[g*DATA_W +: DATA_W]),
            .set_alarm (hit_alarm[g]),
            .set_shut  (hit_shut[g])
        );
    end

    always_comb begin
        fl_d = fl_q;
        if (wr_en && (wr_addr == STAT_ADR)) begin
            clr_alarm = wr_data[ALARM_GRP +: NUM_CH];
            clr_shut  = wr_data[SHUT_GRP +: NUM_CH];
            clr_ready = wr_data[READY_GRP +: NUM_CH];
        end else begin
            clr_alarm = '0;
            clr_shut  = '0;
            clr_ready = '0;
        end
        // Setting takes priority over a write-one-to-clear
        fl_d.alarm = (fl_q.alarm & ~clr_alarm) | hit_alarm;
        fl_d.shut  = (fl_q.shut & ~clr_shut) | hit_shut;
        fl_d.ready = (fl_q.ready & ~clr_ready) | data_valid;

        if (wr_en && (wr_addr == EN_ADR)) begin
            fl_d.en_alarm = wr_data[ALARM_GRP +: NUM_CH];
            fl_d.en_shut  = wr_data[SHUT_GRP +: NUM_CH];
            fl_d.en_ready = wr_data[READY_GRP +: NUM_CH];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    always_comb begin
        status                         = '0;
        status[ALARM_GRP +: NUM_CH]    = fl_q.alarm;
        status[SHUT_GRP +: NUM_CH]     = fl_q.shut;
        status[READY_GRP +: NUM_CH]    = fl_q.ready;
    end

    assign irq = |{fl_q.alarm & fl_q.en_alarm,
                   fl_q.shut & fl_q.en_shut,
                   fl_q.ready & fl_q.en_ready};
    assign shut_req = |fl_q.shut;
endmodule

// File: rtl/thermal_trip_cmp_chk.sv
module thermal_trip_cmp_chk
    import thermal_cmp_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [NUM_CH-1:0] data_valid,
    input logic [REG_W-1:0]  status,
    input logic              irq,
    input logic              shut_req
);
    localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(OFS_STATUS);

    logic stat_wr;
    assign stat_wr = wr_en && (wr_addr == STAT_ADR);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R2 and R7: a strobe leaves the ready flag set, even against a clear
        a_r2_ready_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            data_valid[g] |=> status[READY_GRP + g]);
        // R6: a clear with no competing strobe removes the ready flag
        a_r6_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && wr_data[READY_GRP + g] && !data_valid[g]) |=> !status[READY_GRP + g]);
        // R10: alarm and shutdown flags rise only after a strobe
        a_r10_alarm_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[ALARM_GRP + g]) |-> $past(data_valid[g]));
        a_r10_shut_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[SHUT_GRP + g]) |-> $past(data_valid[g]));
        // R6: flags hold until written with a one
        a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[ALARM_GRP + g] && !(stat_wr && wr_data[ALARM_GRP + g]))
                |=> status[ALARM_GRP + g]);
        a_r6_shut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[SHUT_GRP + g] && !(stat_wr && wr_data[SHUT_GRP + g]))
                |=> status[SHUT_GRP + g]);
    end

    // R8: no interrupt without a pending flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
    // R9: shutdown request tracks the shutdown group
    a_r9_req_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        shut_req |-> (status[SHUT_GRP +: NUM_CH] != '0));
    a_r9_flag_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SHUT_GRP +: NUM_CH] != '0) |-> shut_req);
endmodule

bind thermal_trip_cmp thermal_trip_cmp_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) i_chk (.*);

// File: tb/test_thermal_trip_cmp.sv
`timescale 1ns/100ps
module test_thermal_trip_cmp;
    localparam int NCH = 3;
    localparam int DW  = 12;
    localparam logic [7:0] A_EN   = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [NCH-1:0]    data_valid = '0;
    logic [NCH*DW-1:0] data_code = '0;
    logic [31:0]       status;
    logic              irq;
    logic              shut_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    thermal_trip_cmp #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(8)) i_thermal_trip_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .data_valid (data_valid),
        .data_code  (data_code),
        .status     (status),
        .irq        (irq),
        .shut_req   (shut_req)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus applied at a falling edge, removed at the next
    task automatic step(logic we, logic [7:0] a, logic [31:0] d, int ch, logic [DW-1:0] c);
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        if (ch >= 0) begin
            data_code[ch*DW +: DW] = c;
            data_valid = NCH'(1) << ch;
        end
        @(negedge clk);
        wr_en      = 1'b0;
        data_valid = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1'b1, a, d, -1, '0);
    endtask

    task automatic strobe(int ch, logic [DW-1:0] c);
        step(1'b0, 8'h00, 32'h0, ch, c);
    endtask

    task automatic clear_all();
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        check("R1 status", status, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 shut_req", {31'h0, shut_req}, 32'h0);
    endtask

    task automatic t_alarm_rearm();
        wr(8'h10, 32'h0400_0600);
        strobe(0, 12'h400);
        check("R3 equal code no alarm", status & 32'h7, 32'h0);
        strobe(0, 12'h3FF);
        check("R3/R1 armed at reset, alarm on hotter code", status & 32'h7, 32'h1);
        check("R2 ready ch0", status & 32'h700, 32'h100);
        clear_all();
        strobe(0, 12'h300);
        check("R4 disarmed no alarm", status & 32'h7, 32'h0);
        strobe(0, 12'h600);
        strobe(0, 12'h300);
        check("R4 equal to re-arm limit does not re-arm", status & 32'h7, 32'h0);
        strobe(0, 12'h601);
        check("R4 re-arming strobe sets nothing", status & 32'h7, 32'h0);
        strobe(0, 12'h300);
        check("R4 alarm after re-arm", status & 32'h7, 32'h1);
        clear_all();
    endtask

    task automatic t_shutdown();
        wr(8'h28, 32'h0200_0000);
        strobe(2, 12'h1FF);
        check("R5 shut flag ch2", status, 32'h0000_0440);
        check("R9 request high", {31'h0, shut_req}, 32'h1);
        wr(A_STAT, 32'h40);
        check("R9 request low after clear", {31'h0, shut_req}, 32'h0);
        strobe(2, 12'h1FF);
        check("R5 no hysteresis", status & 32'h70, 32'h40);
        clear_all();
        strobe(2, 12'h200);
        check("R5 equal code no shut", status & 32'h70, 32'h0);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] snap;
        strobe(1, 12'h800);
        strobe(2, 12'h100);
        check("R6 setup", status, 32'h0000_0640);
        wr(A_STAT, 32'h0);
        check("R6 zero write keeps flags", status, 32'h0000_0640);
        wr(A_STAT, 32'h40);
        check("R6 single bit clear", status, 32'h0000_0600);
        snap = status;
        wr(A_STAT, snap);
        check("R6 readback clears all seen", status, 32'h0);
    endtask

    task automatic t_set_wins();
        strobe(0, 12'h800);
        check("R7 setup", status & 32'h107, 32'h100);
        step(1'b1, A_STAT, 32'h100, 0, 12'h800);
        check("R7 set beats clear", status & 32'h100, 32'h100);
        wr(A_STAT, 32'h100);
        check("R7 plain clear", status & 32'h100, 32'h0);
        clear_all();
    endtask

    task automatic t_irq();
        wr(A_EN, 32'h0);
        strobe(2, 12'h100);
        check("R8 masked flags", {31'h0, irq}, 32'h0);
        wr(A_EN, 32'h40);
        check("R8 shut enable", {31'h0, irq}, 32'h1);
        wr(A_EN, 32'h1);
        check("R8 enable without flag", {31'h0, irq}, 32'h0);
        wr(A_EN, 32'h400);
        check("R8 ready enable", {31'h0, irq}, 32'h1);
        clear_all();
        check("R8 cleared flags drop irq", {31'h0, irq}, 32'h0);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_no_strobe();
        data_code[0 +: DW] = 12'h000;
        data_code[DW +: DW] = 12'h000;
        @(negedge clk);
        @(negedge clk);
        check("R10 low code without strobe", status, 32'h0);
        wr(8'h14, 32'h0FFF_0000);
        wr(8'h24, 32'h0FFF_0000);
        check("R10 limit write sets nothing", status, 32'h0);
        strobe(1, 12'h010);
        check("R11 only ch1 bits", status, 32'h0000_0222);
        clear_all();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alarm_rearm();
        t_shutdown();
        t_w1c();
        t_set_wins();
        t_irq();
        t_no_strobe();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end
endmodule